// File: doc/BRIEF.md
# Furnace Heating Sequencer

This block sequences a domestic furnace through four phases: idle, burner ignition, blower run and a forced cooldown hold. It reacts to three condition inputs, each a single-cycle flag that has already been cleaned up elsewhere. The first flag says the room is too cold. The second says the burner chamber is hot enough. The third says the room is warm enough. It drives three Moore outputs: burner enable, blower enable and a cooldown indicator.

The cooldown phase lasts a fixed number of clock cycles, set by a parameter and counted by an internal timer. While cooldown lasts, no thermostat reading can restart the burner. When the timer expires, the sequencer either re-ignites or returns to idle, depending on the thermostat flags in that cycle. A parameter selects whether the outputs are decoded from the state register or held in their own flops. Both choices give the same cycle timing.

Top module: `furnace_ctrl`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the next state is idle (code 0) with the timer cleared, and all three outputs are low after that clock edge.
- R2: In idle (code 0), too-cold without warm-enough moves the sequencer to ignition (code 1) at the next edge. Any other input combination leaves it idle.
- R3: In ignition (code 1), hot-enough moves it to blower run (code 2). Without hot-enough it stays in ignition, whatever the thermostat flags say.
- R4: In blower run (code 2), warm-enough moves it to cooldown (code 3). Otherwise it stays in blower run, including while too-cold is asserted.
- R5: Once entered, cooldown lasts exactly COOL_CYCLES clock cycles. No input ends it early.
- R6: In the last cooldown cycle, too-cold without warm-enough moves the sequencer to ignition. Any other combination moves it to idle.
- R7: The burner enable is never high while the cooldown indicator is high. Cooldown is never followed directly by blower run.
- R8: Output encoding as {burner, blower, cooldown}: idle 000, ignition 100, blower run 110, cooldown 011.
- R9: When too-cold and warm-enough are asserted together, warm-enough takes precedence. In that case idle stays idle, blower run goes to cooldown, and a cooldown exit goes to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cold_i | input | 1 | Thermostat reports too cold |
| hot_i | input | 1 | Burner chamber reports hot enough |
| warm_i | input | 1 | Thermostat reports warm enough |
| burner_o | output | 1 | Burner enable |
| blower_o | output | 1 | Blower enable |
| cool_o | output | 1 | Cooldown phase indicator |

## Verification
The assertions take for granted that the three flags are synchronous to the clock and settled before each rising edge. They do not assume that the flags are mutually exclusive or that any ordering holds between them. The stimulus changes inputs only on the falling edge. It draws the flags independently, so conflicting too-cold and warm-enough pairs and hot-enough pulses outside ignition do occur. Directed steps cover the precedence rule, cooldown exit to each target, and a reset taken mid-cooldown.

// File: rtl/furnace_pkg.sv
package furnace_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_IGNITE = 2'd1,
      ST_RUN    = 2'd2,
      ST_COOL   = 2'd3
   } furn_state_e;
endpackage

// File: rtl/furnace_cool_timer.sv
module furnace_cool_timer #(
   parameter int COOL_CYCLES = 8,
   localparam int CNT_W = (COOL_CYCLES > 1) ? $clog2(COOL_CYCLES) : 1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic run_i,
   output logic expire_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(COOL_CYCLES - 1);

   generate
      if (COOL_CYCLES < 1) begin : g_bad_len
         $error("COOL_CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   assign expire_o = run_i && (cnt_q == LAST);

   always_ff @(posedge clk_i) begin
      if (rst_i || !run_i || expire_o) cnt_q <= '0;
      else                             cnt_q <= cnt_q + 1'b1;
   end

   // R5: count never passes the final cooldown cycle
   p_timer_bound_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= LAST);
   // R5: counter advances one per cooldown cycle until expiry
   p_timer_step_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (run_i && !expire_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/furnace_next.sv
module furnace_next
   import furnace_pkg::*;
(
   input  furn_state_e st_i,
   input  logic        cold_i,
   input  logic        hot_i,
   input  logic        warm_i,
   input  logic        expire_i,
   output furn_state_e st_o
);
   logic want_heat;

   // warm-enough has precedence over too-cold
   assign want_heat = cold_i && !warm_i;

   always_comb begin
      st_o = st_i;
      unique case (st_i)
         ST_IDLE:   if (want_heat) st_o = ST_IGNITE;
         ST_IGNITE: if (hot_i)     st_o = ST_RUN;
         ST_RUN:    if (warm_i)    st_o = ST_COOL;
         ST_COOL:   if (expire_i)  st_o = want_heat ? ST_IGNITE : ST_IDLE;
         default:                  st_o = ST_IDLE;
      endcase
   end
endmodule

// File: rtl/furnace_out_dec.sv
module furnace_out_dec
   import furnace_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic        clk_i,
   input  logic        rst_i,
   input  furn_state_e st_q_i,
   input  furn_state_e st_d_i,
   output logic        burner_o,
   output logic        blower_o,
   output logic        cool_o
);
   function automatic logic [2:0] decode(furn_state_e s);
      logic [2:0] v;
      unique case (s)
         ST_IDLE:   v = 3'b000;
         ST_IGNITE: v = 3'b100;
         ST_RUN:    v = 3'b110;
         ST_COOL:   v = 3'b011;
         default:   v = 3'b000;
      endcase
      return v;
   endfunction

   generate
      if (OUT_REG) begin : g_flop
         logic [2:0] out_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) out_q <= 3'b000;
            else       out_q <= decode(st_d_i);
         end
         assign {burner_o, blower_o, cool_o} = out_q;
      end else begin : g_comb
         assign {burner_o, blower_o, cool_o} = decode(st_q_i);
      end
   endgenerate

   // R7: burner and cooldown are mutually exclusive
   p_no_burn_cool_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      !(burner_o && cool_o));
   // R8: blower is on whenever cooldown is flagged
   p_cool_blower_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      cool_o |-> blower_o);
   // R8: presented state is the one chosen in the prior cycle
   p_state_follow_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> (st_q_i == $past(st_d_i)));
endmodule

// File: rtl/furnace_ctrl.sv
module furnace_ctrl
   import furnace_pkg::*;
#(
   parameter int COOL_CYCLES = 8,
   parameter bit OUT_REG     = 1'b0
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic cold_i,
   input  logic hot_i,
   input  logic warm_i,
   output logic burner_o,
   output logic blower_o,
   output logic cool_o
);
   furn_state_e st_q, st_d;
   logic        expire;

   always_ff @(posedge clk_i) begin
      if (rst_i) st_q <= ST_IDLE;
      else       st_q <= st_d;
   end

   furnace_cool_timer #(.COOL_CYCLES(COOL_CYCLES)) timer_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .run_i   (st_q == ST_COOL),
      .expire_o(expire)
   );

   furnace_next next_i (
      .st_i    (st_q),
      .cold_i  (cold_i),
      .hot_i   (hot_i),
      .warm_i  (warm_i),
      .expire_i(expire),
      .st_o    (st_d)
   );

   furnace_out_dec #(.OUT_REG(OUT_REG)) out_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .st_q_i  (st_q),
      .st_d_i  (st_d),
      .burner_o(burner_o),
      .blower_o(blower_o),
      .cool_o  (cool_o)
   );

   // R1: reset lands in idle
   p_reset_idle_r1: assert property (@(posedge clk_i)
      rst_i |=> (st_q == ST_IDLE));
   // R2: heat request from idle starts ignition
   p_idle_fire_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (st_q == ST_IDLE && cold_i && !warm_i) |=> (st_q == ST_IGNITE));
   // R3: ignition holds until chamber is hot
   p_ign_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (st_q == ST_IGNITE && !hot_i) |=> (st_q == ST_IGNITE));
   // R4: run continues without warm-enough
   p_run_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (st_q == ST_RUN && !warm_i) |=> (st_q == ST_RUN));
   // R5: cooldown is not cut short
   p_cool_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (st_q == ST_COOL && !expire) |=> (st_q == ST_COOL));
   // R6: cooldown always ends when the timer expires
   p_cool_exit_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (st_q == ST_COOL && expire) |=> (st_q != ST_COOL));
   // R7: cooldown never jumps straight back to blower run
   p_no_direct_run_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (st_q == ST_COOL) |=> (st_q != ST_RUN));
   // R9: warm-enough beats too-cold in idle
   p_warm_wins_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (st_q == ST_IDLE && warm_i) |=> (st_q == ST_IDLE));
endmodule

// File: tb/furnace_ctrl_tb_top.sv
`timescale 1ns/1ps
module furnace_ctrl_tb_top;
   localparam int COOL = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cold = 1'b0, hot = 1'b0, warm = 1'b0;
   logic burner, blower, cool;

   int n_run = 0;
   int n_fail = 0;
   int m_st = 0;
   int m_cnt = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   furnace_ctrl #(.COOL_CYCLES(COOL)) dut_i (
      .clk_i(clk), .rst_i(rst), .cold_i(cold), .hot_i(hot), .warm_i(warm),
      .burner_o(burner), .blower_o(blower), .cool_o(cool)
   );

   function automatic logic [2:0] exp_out(int s);
      case (s)
         1: return 3'b100;
         2: return 3'b110;
         3: return 3'b011;
         default: return 3'b000;
      endcase
   endfunction

   function automatic int exp_next(int s, int cnt, bit c, bit h, bit w);
      bit heat = c && !w;
      case (s)
         0: return heat ? 1 : 0;
         1: return h ? 2 : 1;
         2: return w ? 3 : 2;
         default: return (cnt == COOL - 1) ? (heat ? 1 : 0) : 3;
      endcase
   endfunction

   task automatic check(string tag);
      logic [2:0] got = {burner, blower, cool};
      logic [2:0] want = exp_out(m_st);
      n_run++;
      if (got !== want) begin
         n_fail++;
         $display("FAIL %s: outputs got %b expected %b", tag, got, want);
      end
      n_run++;
      if (burner && cool) begin
         n_fail++;
         $display("FAIL R7: burner=%b cool=%b expected not both high", burner, cool);
      end
   endtask

   task automatic step(bit c, bit h, bit w);
      string tag;
      @(negedge clk);
      cold = c; hot = h; warm = w;
      case (m_st)
         0: tag = (c && w) ? "R8/R9" : "R8/R2";
         1: tag = "R8/R3";
         2: tag = (c && w) ? "R8/R9" : "R8/R4";
         default: tag = (m_cnt == COOL - 1) ? ((c && w) ? "R8/R9" : "R8/R6") : "R8/R5";
      endcase
      @(posedge clk);
      begin
         int nxt = exp_next(m_st, m_cnt, c, h, w);
         m_cnt = (m_st == 3 && nxt == 3) ? m_cnt + 1 : 0;
         m_st = nxt;
      end
      #1 check(tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; cold = 0; hot = 0; warm = 0;
      @(posedge clk);
      m_st = 0; m_cnt = 0;
      #1 check("R1");
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: cycles got %0d expected below 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd4711));
      do_reset();
      step(0, 0, 0);              // R2 stays idle
      step(0, 1, 1);              // R2 stays idle
      step(1, 0, 1);              // R9 warm wins in idle
      step(1, 0, 0);              // R2 to ignition
      step(0, 0, 0);              // R3 hold
      step(1, 0, 1);              // R3 hold, thermostat ignored
      step(0, 1, 0);              // R3 to run
      step(1, 0, 0);              // R4 still cold keeps running
      step(1, 0, 1);              // R9 warm wins, to cooldown
      for (int i = 0; i < COOL - 1; i++) step(1, 1, 0);  // R5 hold
      step(1, 0, 0);              // R6 exit to ignition
      step(0, 1, 0);
      step(0, 0, 1);              // back to cooldown
      for (int i = 0; i < COOL - 1; i++) step(0, 0, 0);  // R5
      step(0, 0, 0);              // R6 neither flag: idle
      step(1, 0, 0);
      step(0, 1, 0);
      step(0, 0, 1);
      for (int i = 0; i < COOL - 1; i++) step(1, 0, 1);
      step(1, 0, 1);              // R9 exit with both flags: idle
      step(1, 0, 0);
      step(0, 1, 0);
      step(0, 0, 1);
      step(1, 0, 0);
      do_reset();                 // R1 reset mid-cooldown
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 199) == 0) do_reset();
         else step($urandom_range(0, 99) < 35,
                   $urandom_range(0, 99) < 30,
                   $urandom_range(0, 99) < 25);
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule